// File: doc/BRIEF.md
# Marked-Graph Worst-Case Throughput Evaluator

This engine works out the lowest rate a network of desynchronized processes can reach. Processes joined by bounded queues are modelled as a marked directed graph. Each process is a transition. Each queue is split into two places: a forward place, whose tokens count occupied slots, and a backward place, whose tokens count free slots. The graph is loaded through a configuration port when `start` is pulsed. Each place is described by its producing transition, its consuming transition, its starting token count and a valid bit.

The engine then steps the graph under the slowest legal triggering policy. In each step every transition that is enabled at the start of the step fires, and all of them fire together. A transition that is not enabled waits for the next step. Every marking reached is stored with its step index. When a new marking equals a stored one, the run has entered its periodic loop. The engine reports the loop length L and, for each transition, how many times it fired inside the loop. The worst-case throughput of a transition is its count divided by L. If the history fills before any marking repeats, the engine ends with an overflow flag.

Control is a four-state machine. IDLE waits after reset. RUN performs one step per clock. DONE holds a valid result. OVF holds an overflow result. The transitions are:
- IDLE→RUN, DONE→RUN and OVF→RUN when `start` is seen.
- RUN→DONE when the new marking matches a stored one.
- RUN→OVF when there is no match and the history is full.
- RUN→RUN in every other case.

Top module: `mgt_tput_eval`

## Requirements
- R1: After reset, `busy`, `done`, `overflow`, `loop_len` and every `fire_cnt` field are 0.
- R2: A `start` pulse seen outside RUN captures the configuration. For place p, the producer is `cfg_src[p*TW +: TW]`, the consumer is `cfg_dst[p*TW +: TW]`, the starting tokens are `cfg_init[p*CW +: CW]`, and the place is valid when `cfg_used[p]` is 1. `busy` is 1 from the next cycle on.
- R3: A transition is enabled in a step only when every valid place that it consumes holds at least one token. A transition that consumes no valid place is enabled in every step. Places whose valid bit is 0 have no effect on the result.
- R4: In each step, all enabled transitions fire at once. A valid place gains one token if its producer fired and loses one token if its consumer fired.
- R5: One step is taken per clock. The state reached after step k is compared with every marking stored for steps 0..k-1. At the first match with step j, the engine stops with `loop_len` = k − j and `done` = 1, one cycle after that step (k cycles after the start cycle).
- R6: For each transition t, `fire_cnt[t*LW +: LW]` is the number of times t fired in steps j+1..k. This field is never larger than `loop_len`.
- R7: The history holds HD markings. If a step finds no match while all HD entries are in use, the engine stops with `overflow` = 1 and `done` = 1, and with `loop_len` and `fire_cnt` at 0. A match found while the history is full is reported as a normal result.
- R8: `done`, `overflow`, `loop_len` and `fire_cnt` hold until the next `start`. `busy` and `done` are never 1 together.
- R9: A `start` pulse during RUN is ignored. The run goes on with the configuration it captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture configuration and begin evaluation |
| cfg_src | input | NP*TW | Producing transition of each place |
| cfg_dst | input | NP*TW | Consuming transition of each place |
| cfg_init | input | NP*CW | Starting token count of each place |
| cfg_used | input | NP | Valid bit of each place |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | Result (or overflow) available |
| overflow | output | 1 | History filled before a repeat |
| loop_len | output | LW | Length L of the periodic marking loop |
| fire_cnt | output | NT*LW | Firings of each transition inside the loop |

## Verification
The checker watches the following on every cycle:
- `busy` and `done` are never high together.
- A `start` outside RUN always leads to RUN.
- A result stays stable until the next `start`.
- An overflow always comes with `done` and a zero length.
- A normal result has a length between 1 and HD, and no transition's loop count exceeds that length.

Only the bench scenarios can show that the stepping rule and the loop search give the right numbers. These scenarios are:
- a three-stage chain with one-slot and two-slot queues (rates 1/2 and 1);
- a two-process ring;
- an unbounded token counter whose loop exactly fills the history;
- a drained transient that overflows it.

The bench also checks that invalid places and a mid-run `start` leave the result unchanged, and it checks the latency of each run.

// File: rtl/mgt_pkg.sv
package mgt_pkg;

    // Controller states of the throughput evaluator
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2,
        ST_OVF  = 2'd3
    } mgt_state_e;

endpackage

// File: rtl/mgt_enable.sv
// Decides which transitions may fire in the current step.
module mgt_enable #(
    parameter int NT = 4,
    parameter int NP = 8,
    parameter int CW = 3,
    parameter int TW = 2
) (
    input  logic [NP*CW-1:0] mark,
    input  logic [NP*TW-1:0] dst,
    input  logic [NP-1:0]    used,
    output logic [NT-1:0]    en
);

    for (genvar t = 0; t < NT; t++) begin : g_trans
        always_comb begin
            en[t] = 1'b1;
            for (int p = 0; p < NP; p++) begin
                if (used[p] && (dst[p*TW +: TW] == TW'(t)) &&
                    (mark[p*CW +: CW] == '0)) begin
                    en[t] = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/mgt_update.sv
// Computes the marking after all enabled transitions fire together.
module mgt_update #(
    parameter int NT = 4,
    parameter int NP = 8,
    parameter int CW = 3,
    parameter int TW = 2
) (
    input  logic [NP*CW-1:0] mark,
    input  logic [NP*TW-1:0] src,
    input  logic [NP*TW-1:0] dst,
    input  logic [NP-1:0]    used,
    input  logic [NT-1:0]    fire,
    output logic [NP*CW-1:0] mark_nx
);

    for (genvar p = 0; p < NP; p++) begin : g_place
        logic gain;
        logic lose;
        always_comb begin
            gain = used[p] && fire[src[p*TW +: TW]];
            lose = used[p] && fire[dst[p*TW +: TW]];
            mark_nx[p*CW +: CW] = mark[p*CW +: CW] + CW'(gain) - CW'(lose);
        end
    end

endmodule

// File: rtl/mgt_history.sv
// Stores visited markings with cumulative firing counts and finds repeats.
module mgt_history #(
    parameter int NP = 8,
    parameter int NT = 4,
    parameter int CW = 3,
    parameter int HD = 16,
    parameter int LW = 5
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [LW-1:0]       wr_idx,
    input  logic [NP*CW-1:0]    wr_mark,
    input  logic [NT*LW-1:0]    wr_cum,
    input  logic [LW-1:0]       fill,
    input  logic [NP*CW-1:0]    query,
    output logic                hit,
    output logic [LW-1:0]       hit_idx,
    output logic [NT*LW-1:0]    hit_cum
);

    logic [NP*CW-1:0] mark_mem [HD];
    logic [NT*LW-1:0] cum_mem  [HD];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mark_mem[wr_idx] <= wr_mark;
            cum_mem[wr_idx]  <= wr_cum;
        end
    end

    // Lowest matching index wins; entries at or above fill are stale.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        hit_cum = '0;
        for (int i = HD - 1; i >= 0; i--) begin
            if ((LW'(i) < fill) && (mark_mem[i] == query)) begin
                hit     = 1'b1;
                hit_idx = LW'(i);
                hit_cum = cum_mem[i];
            end
        end
    end

endmodule

// File: rtl/mgt_tput_eval.sv
// Slow-trigger worst-case throughput evaluator for a small marked graph.
module mgt_tput_eval #(
    parameter int NT = 4,
    parameter int NP = 8,
    parameter int CW = 3,
    parameter int HD = 16,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1,
    localparam int LW = $clog2(HD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NP*TW-1:0] cfg_src,
    input  logic [NP*TW-1:0] cfg_dst,
    input  logic [NP*CW-1:0] cfg_init,
    input  logic [NP-1:0]    cfg_used,
    output logic             busy,
    output logic             done,
    output logic             overflow,
    output logic [LW-1:0]    loop_len,
    output logic [NT*LW-1:0] fire_cnt
);
    import mgt_pkg::*;

    localparam int MW = NP * CW;
    localparam int FW = NT * LW;

    mgt_state_e state_q, state_nx;

    logic [NP*TW-1:0] src_q, dst_q;
    logic [NP-1:0]    used_q;
    logic [MW-1:0]    mark_q, mark_nx, init_masked;
    logic [FW-1:0]    cum_q, cum_nx, hit_cum, span_cnt;
    logic [LW-1:0]    fill_q, hit_idx, len_q;
    logic [FW-1:0]    fcnt_q;
    logic [NT-1:0]    fire;
    logic             hit, full, accept, running;
    logic             hist_wr;
    logic [LW-1:0]    hist_idx;
    logic [MW-1:0]    hist_mark;
    logic [FW-1:0]    hist_cum;

    assign running = (state_q == ST_RUN);
    assign accept  = start && !running;
    assign full    = (fill_q == LW'(HD));

    for (genvar p = 0; p < NP; p++) begin : g_init
        assign init_masked[p*CW +: CW] = cfg_used[p] ? cfg_init[p*CW +: CW] : '0;
    end

    for (genvar t = 0; t < NT; t++) begin : g_cnt
        assign cum_nx[t*LW +: LW]   = cum_q[t*LW +: LW] + LW'(fire[t]);
        assign span_cnt[t*LW +: LW] = cum_nx[t*LW +: LW] - hit_cum[t*LW +: LW];
    end

    mgt_enable #(.NT(NT), .NP(NP), .CW(CW), .TW(TW)) u_enable (
        .mark (mark_q),
        .dst  (dst_q),
        .used (used_q),
        .en   (fire)
    );

    mgt_update #(.NT(NT), .NP(NP), .CW(CW), .TW(TW)) u_update (
        .mark    (mark_q),
        .src     (src_q),
        .dst     (dst_q),
        .used    (used_q),
        .fire    (fire),
        .mark_nx (mark_nx)
    );

    always_comb begin
        hist_wr   = accept || (running && !hit && !full);
        hist_idx  = accept ? '0 : fill_q;
        hist_mark = accept ? init_masked : mark_nx;
        hist_cum  = accept ? '0 : cum_nx;
    end

    mgt_history #(.NP(NP), .NT(NT), .CW(CW), .HD(HD), .LW(LW)) u_hist (
        .clk     (clk),
        .wr_en   (hist_wr),
        .wr_idx  (hist_idx),
        .wr_mark (hist_mark),
        .wr_cum  (hist_cum),
        .fill    (fill_q),
        .query   (mark_nx),
        .hit     (hit),
        .hit_idx (hit_idx),
        .hit_cum (hit_cum)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_OVF: if (accept) state_nx = ST_RUN;
            ST_RUN: begin
                if (hit)       state_nx = ST_DONE;
                else if (full) state_nx = ST_OVF;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            used_q <= '0;
            mark_q <= '0;
            cum_q  <= '0;
            fill_q <= '0;
            len_q  <= '0;
            fcnt_q <= '0;
        end else if (accept) begin
            src_q  <= cfg_src;
            dst_q  <= cfg_dst;
            used_q <= cfg_used;
            mark_q <= init_masked;
            cum_q  <= '0;
            fill_q <= LW'(1);
            len_q  <= '0;
            fcnt_q <= '0;
        end else if (running) begin
            mark_q <= mark_nx;
            cum_q  <= cum_nx;
            if (hit) begin
                len_q  <= fill_q - hit_idx;
                fcnt_q <= span_cnt;
            end else if (!full) begin
                fill_q <= fill_q + LW'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        overflow = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  busy = 1'b1;
            ST_DONE: done = 1'b1;
            ST_OVF: begin
                done     = 1'b1;
                overflow = 1'b1;
            end
            default: ;
        endcase
        loop_len = len_q;
        fire_cnt = fcnt_q;
    end

endmodule

// File: rtl/mgt_tput_eval_chk.sv
module mgt_tput_eval_chk #(
    parameter int NT = 4,
    parameter int HD = 16,
    parameter int LW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          overflow,
    input logic [LW-1:0] loop_len,
    input logic [NT*LW-1:0] fire_cnt
);

    // R8
    state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R2
    start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(loop_len) && $stable(overflow)
                              && $stable(fire_cnt)));

    // R7
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (done && loop_len == '0 && fire_cnt == '0));

    // R5
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !overflow) |-> (loop_len != '0 && loop_len <= LW'(HD)));

    // R9
    run_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    for (genvar t = 0; t < NT; t++) begin : g_fc
        // R6
        fire_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (fire_cnt[t*LW +: LW] <= loop_len));
    end

endmodule

bind mgt_tput_eval mgt_tput_eval_chk #(.NT(NT), .HD(HD), .LW(LW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .overflow (overflow),
    .loop_len (loop_len),
    .fire_cnt (fire_cnt)
);

// File: tb/mgt_tput_eval_test.sv
module mgt_tput_eval_test;

    localparam int NT = 4;
    localparam int NP = 8;
    localparam int CW = 3;
    localparam int HD = 8;
    localparam int TW = 2;
    localparam int LW = 4;

    typedef struct {
        string name;
        int    len;
        int    f [NT];
        bit    ovf;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [NP*TW-1:0] cfg_src = '0;
    logic [NP*TW-1:0] cfg_dst = '0;
    logic [NP*CW-1:0] cfg_init = '0;
    logic [NP-1:0]    cfg_used = '0;
    logic             busy, done, overflow;
    logic [LW-1:0]    loop_len;
    logic [NT*LW-1:0] fire_cnt;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    bit done_d = 1'b0;
    exp_t sb [$];

    always #2 clk = ~clk;   // 250 MHz

    mgt_tput_eval #(.NT(NT), .NP(NP), .CW(CW), .HD(HD)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_init(cfg_init),
        .cfg_used(cfg_used), .busy(busy), .done(done), .overflow(overflow),
        .loop_len(loop_len), .fire_cnt(fire_cnt)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_clear();
        cfg_src = '0; cfg_dst = '0; cfg_init = '0; cfg_used = '0;
    endtask

    task automatic place(input int p, input int s, input int d, input int i, input bit u);
        cfg_src[p*TW +: TW]  = TW'(s);
        cfg_dst[p*TW +: TW]  = TW'(d);
        cfg_init[p*CW +: CW] = CW'(i);
        cfg_used[p]          = u;
    endtask

    // Driver: queue the expectation, pulse start, check busy and latency.
    task automatic run(input exp_t e, input int steps, input string req);
        int c;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", {e.name, " busy"}, int'(busy), 1);
        c = 0;
        while (!done && c < 200) begin
            @(negedge clk);
            c++;
        end
        chk(req, {e.name, " latency"}, c, steps);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pop and compare at each new result.
    always @(negedge clk) begin
        if (rst_n && done && !done_d) begin
            if (sb.size() == 0) begin
                chk("R5", "unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.ovf ? "R7" : "R5", {e.name, " loop_len"}, int'(loop_len), e.len);
                chk("R7", {e.name, " overflow"}, int'(overflow), int'(e.ovf));
                for (int t = 0; t < NT; t++)
                    chk("R6", {e.name, " fire_cnt"}, int'(fire_cnt[t*LW +: LW]), e.f[t]);
            end
        end
        done_d = done;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        exp_t e;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "overflow", int'(overflow), 0);
        chk("R1", "loop_len", int'(loop_len), 0);
        chk("R1", "fire_cnt", int'(fire_cnt), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4: three-stage chain, one-slot queues -> rate 1/2
        cfg_clear();
        place(0, 0, 1, 0, 1); place(1, 1, 0, 1, 1);
        place(2, 1, 2, 0, 1); place(3, 2, 1, 1, 1);
        e.name = "chain1"; e.len = 2; e.f = '{1, 1, 1, 2}; e.ovf = 0;
        run(e, 3, "R4");

        // R3: invalid place with tokens aimed at T0 has no effect
        place(4, 2, 0, 5, 0);
        e.name = "chain1_unused";
        run(e, 3, "R3");

        // R4: two-slot queues -> rate 1
        cfg_clear();
        place(0, 0, 1, 0, 1); place(1, 1, 0, 2, 1);
        place(2, 1, 2, 0, 1); place(3, 2, 1, 2, 1);
        e.name = "chain2"; e.len = 1; e.f = '{1, 1, 1, 1}; e.ovf = 0;
        run(e, 3, "R5");

        // R4: two-process ring
        cfg_clear();
        place(0, 0, 1, 1, 1); place(1, 1, 0, 0, 1);
        e.name = "ring"; e.len = 2; e.f = '{1, 1, 2, 2}; e.ovf = 0;
        run(e, 2, "R4");

        // R7 boundary: loop of HD fills history, still a match
        cfg_clear();
        place(0, 0, 1, 0, 1); place(1, 1, 1, 0, 1);
        e.name = "counter"; e.len = 8; e.f = '{8, 0, 8, 8}; e.ovf = 0;
        run(e, 8, "R7");

        // R7: transient plus loop exceeds history
        place(2, 1, 2, 3, 1);
        e.name = "overflow"; e.len = 0; e.f = '{0, 0, 0, 0}; e.ovf = 1;
        run(e, 8, "R7");

        // R9: start during RUN ignored
        cfg_clear();
        place(0, 0, 1, 0, 1); place(1, 1, 1, 0, 1);
        e.name = "no_restart"; e.len = 8; e.f = '{8, 0, 8, 8}; e.ovf = 0;
        sb.push_back(e);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        cfg_clear();
        place(0, 0, 1, 1, 1); place(1, 1, 0, 0, 1);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R9", "busy after ignored start", int'(busy), 1);
        begin
            int c;
            c = 2;
            while (!done && c < 200) begin
                @(negedge clk);
                c++;
            end
            chk("R9", "latency", c, 8);
        end

        // R8: result holds while start stays low
        repeat (5) @(negedge clk);
        chk("R8", "done held", int'(done), 1);
        chk("R8", "loop_len held", int'(loop_len), 8);
        chk("R8", "busy low", int'(busy), 0);
        chk("R5", "scoreboard drained", sb.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule